// File: doc/BRIEF.md
# I2C Target Byte Responder

This block is the target side of an I2C controller. Once switched on, it watches the bus for a START condition and collects the first byte. It compares the seven address bits of that byte with a programmable own address. If the address does not match, the block stays silent until the next START.

If the address matches, every byte is passed to the host one at a time. This includes the address byte itself, which carries its read/write bit. Each byte raises a receive event. The block stretches SCL low until the host clears that event, and then it acknowledges the byte. In a read, the block holds SCL low before each reply byte. It waits for the host to load a byte and issue a transmit command, then shifts the byte out with the most significant bit first. It reports whether the master acknowledged the byte. Events sit in a write-one-to-clear status register. An enable register with the same bit positions gates them onto a single interrupt line.

The control state machine has eight states:
- **IDLE**: ignores the bus.
- **ADDR**: shifts in the address byte.
- **RX_DATA**: shifts in a write byte.
- **BYTE_END**: waits for the falling SCL edge after the 8th bit.
- **ACK_OUT**: drives ACK, holding SCL while the receive event is pending.
- **TX_WAIT**: holds SCL until a transmit command arrives.
- **TX_BITS**: shifts a byte out.
- **TX_ACK**: samples the master's acknowledge.

Its transitions are:
- **start**: from any state to ADDR.
- **stop**: from any state to IDLE.
- **mismatch**: ADDR to IDLE.
- **byte_full**: ADDR or RX_DATA to BYTE_END.
- **ack_slot**: BYTE_END to ACK_OUT.
- **to_write**: ACK_OUT to RX_DATA.
- **to_read**: ACK_OUT to TX_WAIT.
- **load**: TX_WAIT to TX_BITS.
- **last_bit**: TX_BITS to TX_ACK.
- **more**: TX_ACK to TX_WAIT.
- **done**: TX_ACK to IDLE.
- **off**: any state to IDLE.

Top module: `i2c_target_responder`

## Requirements
- R1: While the enable bit (bit 1 of register 0) is clear, the block drives neither SDA nor SCL and sets no status bit, so an address byte equal to the own address is not acknowledged.
- R2: With the block enabled, the first byte after START whose bits 7:1 equal bits 6:0 of register 1 sets status bit 7 (match) and bit 2 (receive done). That byte, including its R/W bit, reads back in bits 15:8 of register 5, and it is acknowledged (SDA low in the 9th clock).
- R3: When the address does not match, the byte is not acknowledged and no status bit is set. Every later byte is ignored until the next START, even a byte equal to the own address.
- R4: In a write, each data byte sets status bit 2, reads back in bits 15:8 of register 5, and is acknowledged.
- R5: While status bit 2 is pending after a received byte, SCL is held low. After the host clears the bit, SCL is released and the ACK is presented.
- R6: After a read address is acknowledged, SCL is held low until the host writes bit 2 of register 4. The byte in bits 7:0 of register 5 is then shifted out MSB first, with SDA changing only while SCL is low.
- R7: After a sent byte, a master ACK sets status bit 0 and the block holds SCL for the next byte. A master NAK sets status bit 1 and the block releases the bus.
- R8: A STOP after a matched address sets status bit 4. A STOP with no match since the last START sets nothing.
- R9: Writing register 3 clears each status bit written as 1. Bits written as 0 are unchanged, and no status bit sets without its event.
- R10: The irq output is high exactly when some status bit and the same bit of register 2 are both set.
- R11: A repeated START restarts the address phase, so a read can follow a write without a STOP between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write index |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 3 | Register read index |
| reg_rdata | output | 16 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
Some behaviours are checked by assertions on every cycle:
- the drives stay released while the block is off;
- SDA changes only during the low phase of SCL;
- a stretched SCL really reads low;
- status bits clear on a write of one and never appear without an event.

Other behaviours can only be shown by the bench's scenarios against its behavioural model:
- address comparison, the mismatch-then-ignore rule and byte contents;
- the ACK and NAK outcomes;
- whether a STOP is reported;
- interrupt masking.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS);
    localparam int OWN_W     = 7;
    localparam int EV_W      = 8;
    localparam int RA_W      = 3;
    localparam int RD_W      = 2 * BYTE_BITS;

    localparam int EVB_TXACK  = 0;
    localparam int EVB_TXNAK  = 1;
    localparam int EVB_RXDONE = 2;
    localparam int EVB_STOP   = 4;
    localparam int EVB_MATCH  = 7;

    localparam logic [RA_W-1:0] RA_CTRL = 3'd0;
    localparam logic [RA_W-1:0] RA_OWN  = 3'd1;
    localparam logic [RA_W-1:0] RA_IEN  = 3'd2;
    localparam logic [RA_W-1:0] RA_STAT = 3'd3;
    localparam logic [RA_W-1:0] RA_CMD  = 3'd4;
    localparam logic [RA_W-1:0] RA_DATA = 3'd5;

    localparam int CTRL_EN_BIT = 1;
    localparam int CMD_TX_BIT  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX_DATA,
        ST_BYTE_END,
        ST_ACK_OUT,
        ST_TX_WAIT,
        ST_TX_BITS,
        ST_TX_ACK
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [RA_W-1:0]      reg_waddr,
    input  logic [BYTE_BITS-1:0] reg_wdata,
    input  logic [RA_W-1:0]      reg_raddr,
    output logic [RD_W-1:0]      reg_rdata,
    input  logic [EV_W-1:0]      ev,
    input  logic [BYTE_BITS-1:0] rx_byte_in,
    output logic                 en,
    output logic [OWN_W-1:0]     own_addr,
    output logic [BYTE_BITS-1:0] tx_byte,
    output logic                 tx_go,
    output logic                 rx_pend,
    output logic                 irq
);
    logic [EV_W-1:0]      stat;
    logic [EV_W-1:0]      ien;
    logic [BYTE_BITS-1:0] rx_byte;
    logic [EV_W-1:0]      w1c;

    always_comb begin
        w1c     = (reg_wr && reg_waddr == RA_STAT) ? reg_wdata : '0;
        tx_go   = reg_wr && reg_waddr == RA_CMD && reg_wdata[CMD_TX_BIT];
        rx_pend = stat[EVB_RXDONE];
        irq     = |(stat & ien);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en       <= 1'b0;
            own_addr <= '0;
            ien      <= '0;
            stat     <= '0;
            tx_byte  <= '0;
            rx_byte  <= '0;
        end else begin
            stat <= (stat & ~w1c) | ev;
            if (ev[EVB_RXDONE]) rx_byte <= rx_byte_in;
            if (reg_wr) begin
                unique case (reg_waddr)
                    RA_CTRL: en       <= reg_wdata[CTRL_EN_BIT];
                    RA_OWN:  own_addr <= reg_wdata[OWN_W-1:0];
                    RA_IEN:  ien      <= reg_wdata;
                    RA_DATA: tx_byte  <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_raddr)
            RA_CTRL: reg_rdata = RD_W'({en, 1'b0});
            RA_OWN:  reg_rdata = RD_W'(own_addr);
            RA_IEN:  reg_rdata = RD_W'(ien);
            RA_STAT: reg_rdata = RD_W'(stat);
            RA_DATA: reg_rdata = {rx_byte, tx_byte};
            default: reg_rdata = '0;
        endcase
    end

    // R9
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_waddr == RA_STAT && ev == '0) |=> ((stat & $past(reg_wdata)) == '0));

    // R9
    stat_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat) & ~$past(ev)) == '0));
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [OWN_W-1:0]     own_addr,
    input  logic                 scl_s,
    input  logic                 sda_s,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic                 rx_pend,
    input  logic                 tx_go,
    input  logic [BYTE_BITS-1:0] tx_byte,
    output logic                 sda_oe,
    output logic                 scl_oe,
    output logic [EV_W-1:0]      ev,
    output logic [BYTE_BITS-1:0] rx_byte
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

    tgt_state_e           state, state_n;
    logic [BYTE_BITS-1:0] shreg, shreg_n;
    logic [CNT_W-1:0]     bitcnt, bitcnt_n;
    logic                 rw, rw_n;
    logic                 mack, mack_n;
    logic                 engaged, engaged_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bitcnt  <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            engaged <= 1'b0;
        end else begin
            state   <= state_n;
            shreg   <= shreg_n;
            bitcnt  <= bitcnt_n;
            rw      <= rw_n;
            mack    <= mack_n;
            engaged <= engaged_n;
        end
    end

    always_comb begin
        state_n   = state;
        shreg_n   = shreg;
        bitcnt_n  = bitcnt;
        rw_n      = rw;
        mack_n    = mack;
        engaged_n = engaged;
        ev        = '0;
        rx_byte   = {shreg[BYTE_BITS-2:0], sda_s};
        if (!en) begin
            state_n   = ST_IDLE;
            engaged_n = 1'b0;
        end else if (stop_det) begin
            ev[EVB_STOP] = engaged;
            state_n      = ST_IDLE;
            engaged_n    = 1'b0;
        end else if (start_det) begin
            state_n   = ST_ADDR;
            bitcnt_n  = '0;
            engaged_n = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR, ST_RX_DATA: begin
                    if (scl_rise) begin
                        shreg_n  = rx_byte;
                        bitcnt_n = bitcnt + 1'b1;
                        if (bitcnt == LAST_BIT) begin
                            if (state == ST_RX_DATA) begin
                                ev[EVB_RXDONE] = 1'b1;
                                state_n        = ST_BYTE_END;
                            end else if (rx_byte[BYTE_BITS-1:1] == own_addr) begin
                                ev[EVB_RXDONE] = 1'b1;
                                ev[EVB_MATCH]  = 1'b1;
                                rw_n           = rx_byte[0];
                                engaged_n      = 1'b1;
                                state_n        = ST_BYTE_END;
                            end else begin
                                state_n = ST_IDLE;
                            end
                        end
                    end
                end
                ST_BYTE_END: if (scl_fall) state_n = ST_ACK_OUT;
                ST_ACK_OUT: begin
                    if (scl_fall) begin
                        bitcnt_n = '0;
                        state_n  = rw ? ST_TX_WAIT : ST_RX_DATA;
                    end
                end
                ST_TX_WAIT: begin
                    if (tx_go) begin
                        shreg_n  = tx_byte;
                        bitcnt_n = '0;
                        state_n  = ST_TX_BITS;
                    end
                end
                ST_TX_BITS: begin
                    if (scl_fall) begin
                        if (bitcnt == LAST_BIT) begin
                            state_n = ST_TX_ACK;
                        end else begin
                            shreg_n  = {shreg[BYTE_BITS-2:0], 1'b0};
                            bitcnt_n = bitcnt + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        mack_n        = ~sda_s;
                        ev[EVB_TXACK] = ~sda_s;
                        ev[EVB_TXNAK] = sda_s;
                    end else if (scl_fall) begin
                        state_n = mack ? ST_TX_WAIT : ST_IDLE;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sda_oe = (state == ST_ACK_OUT) || (state == ST_TX_BITS && !shreg[BYTE_BITS-1]);
        scl_oe = (state == ST_ACK_OUT && rx_pend) || (state == ST_TX_WAIT);
    end

    // R1
    off_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> (!sda_oe && !scl_oe));

    // R6
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(start_det || stop_det) && (sda_oe != $past(sda_oe)))
        |-> !$past(scl_s));
endmodule

// File: rtl/i2c_target_responder.sv
module i2c_target_responder
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 scl_oe,
    output logic                 sda_oe,
    input  logic                 reg_wr,
    input  logic [RA_W-1:0]      reg_waddr,
    input  logic [BYTE_BITS-1:0] reg_wdata,
    input  logic [RA_W-1:0]      reg_raddr,
    output logic [RD_W-1:0]      reg_rdata,
    output logic                 irq
);
    logic                 scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic                 en, tx_go, rx_pend;
    logic [OWN_W-1:0]     own_addr;
    logic [BYTE_BITS-1:0] tx_byte, rx_byte;
    logic [EV_W-1:0]      ev;

    i2c_tgt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .ev(ev), .rx_byte_in(rx_byte), .en(en), .own_addr(own_addr),
        .tx_byte(tx_byte), .tx_go(tx_go), .rx_pend(rx_pend), .irq(irq)
    );

    i2c_tgt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .own_addr(own_addr),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .rx_pend(rx_pend),
        .tx_go(tx_go), .tx_byte(tx_byte), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .ev(ev), .rx_byte(rx_byte)
    );

    // R5
    hold_reads_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> !scl_s);
endmodule

// File: tb/i2c_target_responder_test.sv
module i2c_target_responder_test;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        scl_oe, sda_oe;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_waddr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [2:0]  reg_raddr = 3'd3;
    logic [15:0] reg_rdata;
    logic        irq;
    logic        bus_scl, bus_sda;

    int cyc = 0, t_mark = 0;
    int chk_a = 0, err_a = 0, chk_b = 0, err_b = 0;
    logic [7:0] m_stat = '0;
    logic [7:0] m_ien = '0;

    assign bus_scl = scl_m & ~scl_oe;
    assign bus_sda = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    i2c_target_responder uut (
        .clk(clk), .rst_n(rst_n), .scl_i(bus_scl), .sda_i(bus_sda),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Per-clock comparison against the behavioural model (R9, R10, R2, R4, R7, R8)
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && (cyc - t_mark) > 6) begin
            chk_a = chk_a + 1;
            if (irq !== |(m_stat & m_ien)) begin
                err_a = err_a + 1;
                if (err_a < 10) $display("FAIL R10 irq cycle %0d actual=%b expected=%b", cyc, irq, |(m_stat & m_ien));
            end
            if (reg_raddr == 3'd3 && reg_rdata[7:0] !== m_stat) begin
                err_a = err_a + 1;
                if (err_a < 10) $display("FAIL R9 status cycle %0d actual=%h expected=%h", cyc, reg_rdata[7:0], m_stat);
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", err_a + err_b + 1, chk_a + chk_b + 1);
        $finish;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        chk_b = chk_b + 1;
        if (act !== exp) begin
            err_b = err_b + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic mark();
        t_mark = cyc;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        if (a == 3'd3) m_stat = m_stat & ~d;
        if (a == 3'd2) m_ien = d;
        mark();
        @(negedge clk);
        reg_wr = 1'b0;
        mark();
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_raddr = a;
        #1 v = reg_rdata;
        reg_raddr = 3'd3;
    endtask

    task automatic scl_up();
        scl_m = 1'b1;
        while (bus_scl !== 1'b1) @(negedge clk);
        mark();
    endtask

    task automatic start_cond();
        sda_m = 1'b1; hq();
        scl_up(); hq();
        sda_m = 1'b0; mark(); hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic stop_cond(input logic [7:0] evm);
        sda_m = 1'b0; hq();
        scl_up(); hq();
        sda_m = 1'b1; m_stat = m_stat | evm; mark(); hq();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic [7:0] evm);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hq();
            scl_up();
            if (i == 0) m_stat = m_stat | evm;
            mark(); hq();
            scl_m = 1'b0; hq();
        end
    endtask

    task automatic ack_phase(output logic a);
        sda_m = 1'b1; hq();
        scl_up(); hq();
        a = bus_sda;
        scl_m = 1'b0; hq();
    endtask

    task automatic recv_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1;
            scl_up(); hq();
            b[i] = bus_sda;
            scl_m = 1'b0; hq();
        end
    endtask

    task automatic master_ack(input logic nak, input logic [7:0] evm);
        sda_m = nak; hq();
        scl_up();
        m_stat = m_stat | evm; mark(); hq();
        scl_m = 1'b0; hq();
        sda_m = 1'b1; hq();
    endtask

    task automatic hold_check(input string req);
        scl_m = 1'b1;
        repeat (20) @(negedge clk);
        check(req, {15'd0, bus_scl}, 16'd0);
        scl_m = 1'b0; hq();
    endtask

    task automatic service_rx(input string req, input logic [7:0] exp, input logic [7:0] clr);
        logic [15:0] v;
        hold_check("R5 SCL held while byte pending");
        reg_read(3'd5, v);
        check(req, {8'd0, v[15:8]}, {8'd0, exp});
        reg_write(3'd3, clr);
    endtask

    initial begin
        logic        a;
        logic [7:0]  b;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mark();
        repeat (10) @(negedge clk);
        reg_read(3'd3, v); check("R9 reset status", v, 16'h0000);
        reg_read(3'd0, v); check("R1 reset control", v, 16'h0000);
        check("R10 reset irq", {15'd0, irq}, 16'd0);
        check("R1 reset bus idle", {14'd0, bus_scl, bus_sda}, 16'h0003);

        // R1: disabled block ignores its own address
        reg_write(3'd1, 8'h42);
        start_cond();
        send_byte(8'h84, 8'h00);
        ack_phase(a); check("R1 no ACK while disabled", {15'd0, a}, 16'd1);
        stop_cond(8'h00);
        reg_read(3'd3, v); check("R1 no status while disabled", v, 16'h0000);

        // R2, R4, R5, R9: write transaction
        reg_write(3'd0, 8'h02);
        reg_write(3'd2, 8'h97);
        start_cond();
        send_byte(8'h84, 8'h84);
        reg_read(3'd3, v); check("R2 match and receive bits", v, 16'h0084);
        check("R10 irq on match", {15'd0, irq}, 16'd1);
        service_rx("R2 address byte in buffer", 8'h84, 8'h80);
        reg_read(3'd3, v); check("R9 only written bit cleared", v, 16'h0004);
        reg_write(3'd3, 8'h01);
        reg_read(3'd3, v); check("R9 clearing an unset bit is harmless", v, 16'h0004);
        hold_check("R5 still held after unrelated clear");
        reg_write(3'd3, 8'h04);
        ack_phase(a); check("R2 address ACK", {15'd0, a}, 16'd0);
        send_byte(8'hA5, 8'h04);
        service_rx("R4 first data byte", 8'hA5, 8'h04);
        ack_phase(a); check("R4 data ACK", {15'd0, a}, 16'd0);
        send_byte(8'h3C, 8'h04);
        service_rx("R4 second data byte", 8'h3C, 8'h04);
        ack_phase(a); check("R4 second ACK", {15'd0, a}, 16'd0);
        stop_cond(8'h10);
        reg_read(3'd3, v); check("R8 stop after match", v, 16'h0010);
        reg_write(3'd3, 8'h10);

        // R3, R8: mismatch then own address in same frame
        start_cond();
        send_byte(8'h90, 8'h00);
        ack_phase(a); check("R3 no ACK on mismatch", {15'd0, a}, 16'd1);
        send_byte(8'h84, 8'h00);
        ack_phase(a); check("R3 later byte ignored", {15'd0, a}, 16'd1);
        stop_cond(8'h00);
        reg_read(3'd3, v); check("R8 no stop flag without match", v, 16'h0000);

        // R11, R6, R7: write pointer, repeated START, read two bytes
        start_cond();
        send_byte(8'h84, 8'h84);
        service_rx("R2 write address again", 8'h84, 8'h84);
        ack_phase(a); check("R2 ACK", {15'd0, a}, 16'd0);
        start_cond();
        send_byte(8'h85, 8'h84);
        service_rx("R11 read address after repeated START", 8'h85, 8'h84);
        ack_phase(a); check("R11 read address ACK", {15'd0, a}, 16'd0);
        hold_check("R6 SCL held before transmit command");
        reg_write(3'd5, 8'hC3);
        reg_write(3'd4, 8'h04);
        recv_byte(b); check("R6 first reply byte", {8'd0, b}, 16'h00C3);
        master_ack(1'b0, 8'h01);
        reg_read(3'd3, v); check("R7 master ACK flag", v, 16'h0001);
        reg_write(3'd3, 8'h01);
        hold_check("R7 SCL held for next byte");
        reg_write(3'd5, 8'h5A);
        reg_write(3'd4, 8'h04);
        recv_byte(b); check("R6 second reply byte", {8'd0, b}, 16'h005A);
        master_ack(1'b1, 8'h02);
        check("R7 bus released after NAK", {14'd0, bus_scl, bus_sda}, 16'h0001);
        stop_cond(8'h10);
        reg_read(3'd3, v); check("R7 NAK and stop flags", v, 16'h0012);

        // R10: enable masking
        reg_write(3'd2, 8'h00);
        repeat (4) @(negedge clk);
        check("R10 irq masked", {15'd0, irq}, 16'd0);
        reg_write(3'd2, 8'h02);
        repeat (4) @(negedge clk);
        check("R10 irq on enabled NAK bit", {15'd0, irq}, 16'd1);
        reg_write(3'd3, 8'h12);
        repeat (10) @(negedge clk);
        check("R10 irq drops after clear", {15'd0, irq}, 16'd0);

        $display("Result: errors=%0d of %0d checks", err_a + err_b, chk_a + chk_b);
        $finish;
    end
endmodule